// File: doc/BRIEF.md
# Serial two-wire register access slave

This block is a slave on a two-wire serial bus (I2C). It runs from a fast system clock that oversamples the bus lines, and it gives an external bus master access to a small bank of byte-wide registers held in neighbouring storage logic. Both bus lines pass through a short synchronizer. The block finds START, repeated START and STOP conditions and the SCL edges on the synchronized lines. It compares the first byte of each transaction with a fixed device prefix and two address-select pins, and it answers by pulling SDA low through an open-drain enable.

A write has three bytes: the device byte with the direction bit clear, a register address and one data byte. For that data byte the block gives the storage logic a single write strobe, together with the register index and the data. A read starts with the same device byte and address byte, which set an internal pointer. A repeated START and a device byte with the direction bit set follow. From then on the block returns bytes from the storage read port, MSB first, for as long as the master acknowledges. The pointer steps by one after every byte and wraps from the top register back to zero.

A power-up busy input makes the block ignore START conditions. A STOP always returns it to standby.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset, sdaOe is 0, regWrEn is 0 and regAddr is 0.
- R2: A device byte is acknowledged only when byte bits [7:3] are 10100 and bits [2:1] equal devSel[1:0]. Bit 0 is the direction: 1 for read, 0 for write. The acknowledge is sdaOe=1 through the ninth SCL clock.
- R3: If the device byte does not match, SDA is not pulled low and no write strobe is given until the next START.
- R4: An address byte below 16 is acknowledged and loads the pointer. An address byte of 16 or more is not acknowledged, and the rest of the transaction up to the next START or STOP gets no acknowledge and no write.
- R5: In a write, the data byte is acknowledged. regWrEn pulses for exactly one cycle, with regAddr equal to the address byte and regWrData equal to the data byte. Any further bytes before STOP are not acknowledged and not written.
- R6: A read returns the register at the pointer, MSB first. The pointer then advances by one after each byte and wraps from 15 to 0.
- R7: When the master does not acknowledge a read byte, SDA is released. The block does not drive SDA again until a new START.
- R8: While busyIn is 1, a START is ignored, so the transaction that follows gets no acknowledge and no write.
- R9: After a STOP, clocked bytes that have no START in front of them get no acknowledge.
- R10: sdaOe only rises while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | SCL level seen on the bus |
| sdaIn | input | 1 | SDA level seen on the bus |
| sdaOe | output | 1 | Pull SDA low when 1 (open drain) |
| devSel | input | 2 | Pin-selected low device address bits |
| busyIn | input | 1 | Power-up busy; START ignored while 1 |
| regAddr | output | 4 | Register index for read and write |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Data to write |
| regRdData | input | 8 | Combinational read data for regAddr |

## Verification
The assertions assume that SCL and SDA each stay stable for several system clocks, so that every bus change is seen as a clean edge on the synchronized lines. They also assume that SDA changes while SCL is high only to form a START or a STOP. The stimulus holds every SCL phase for ten clocks and moves the master's SDA four clocks after SCL falls, which is after the slave has released its previous drive. START and STOP are made only while SCL is held high. The assertions further take regRdData to be a pure function of regAddr, and the bench provides that with a plain array that it indexes directly.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RXID, ST_ACKID, ST_RXADDR, ST_ACKADDR,
    ST_RXDATA, ST_ACKDATA, ST_TX, ST_TXACK, ST_TXWAIT, ST_SKIP
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic ackOn;
    logic relSda;
    logic ptrLoad;
    logic ptrInc;
    logic wrStb;
  } dpCmd_t;

  // events and decodes from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaNow;
    logic byteDone;
    logic idMatch;
    logic rwBit;
    logic addrOk;
  } dpStat_t;
endpackage

// File: rtl/i2c_reg_dp.sv
module i2c_reg_dp
  import i2c_reg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_REGS    = 16,
  parameter logic [4:0] DEV_PREFIX  = 5'b10100,
  parameter int         ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        devSel,
  input  dpCmd_t            cmd,
  output dpStat_t           stat,
  output logic              sclSync,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  input  logic [BYTE_W-1:0] regRdData
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclLast, sdaLast, sclS, sdaS;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclLast <= 1'b1;
      sdaLast <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclLast <= sclS;
      sdaLast <= sdaS;
    end
  end

  assign sclS    = sclPipe[SYNC_STAGES-1];
  assign sdaS    = sdaPipe[SYNC_STAGES-1];
  assign sclSync = sclS;

  always_comb begin
    stat.sclRise   = sclS & ~sclLast;
    stat.sclFall   = ~sclS & sclLast;
    stat.startSeen = sclS & sclLast & sdaLast & ~sdaS;
    stat.stopSeen  = sclS & sclLast & ~sdaLast & sdaS;
    stat.sdaNow    = sdaS;
    stat.byteDone  = (bitCnt == CNT_W'(BYTE_W));
    stat.idMatch   = (shiftReg[7:1] == {DEV_PREFIX, devSel});
    stat.rwBit     = shiftReg[0];
    stat.addrOk    = (shiftReg < BYTE_W'(NUM_REGS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
      sdaOe    <= 1'b0;
      ptr      <= '0;
      regWrEn  <= 1'b0;
    end else begin
      regWrEn <= cmd.wrStb;
      if (cmd.clrCnt) begin
        bitCnt <= '0;
      end else if (cmd.rxShift) begin
        shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
        bitCnt   <= bitCnt + 1'b1;
      end else if (cmd.txLoad) begin
        shiftReg <= regRdData;
        bitCnt   <= CNT_W'(1);
      end else if (cmd.txShift) begin
        shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
        bitCnt   <= bitCnt + 1'b1;
      end
      if (cmd.relSda)       sdaOe <= 1'b0;
      else if (cmd.ackOn)   sdaOe <= 1'b1;
      else if (cmd.txLoad)  sdaOe <= ~regRdData[BYTE_W-1];
      else if (cmd.txShift) sdaOe <= ~shiftReg[BYTE_W-2];
      if (cmd.ptrLoad)     ptr <= shiftReg[ADDR_W-1:0];
      else if (cmd.ptrInc) ptr <= ptr + 1'b1;
    end
  end

  assign regAddr   = ptr;
  assign regWrData = shiftReg;
endmodule

// File: rtl/i2c_reg_ctrl.sv
module i2c_reg_ctrl
  import i2c_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busyIn,
  input  dpStat_t    stat,
  output dpCmd_t     cmd,
  output ctrlState_t curState
);
  ctrlState_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    cmd = '0;
    nxt = state;
    if (stat.stopSeen) begin
      nxt        = ST_IDLE;
      cmd.relSda = 1'b1;
      cmd.clrCnt = 1'b1;
    end else if (stat.startSeen && !busyIn) begin
      nxt        = ST_RXID;
      cmd.relSda = 1'b1;
      cmd.clrCnt = 1'b1;
    end else begin
      case (state)
        ST_RXID, ST_RXADDR, ST_RXDATA: begin
          if (stat.sclRise && !stat.byteDone) begin
            cmd.rxShift = 1'b1;
          end else if (stat.sclFall && stat.byteDone) begin
            if (state == ST_RXID) begin
              if (stat.idMatch) begin
                cmd.ackOn = 1'b1;
                nxt       = ST_ACKID;
              end else begin
                nxt = ST_SKIP;
              end
            end else if (state == ST_RXADDR) begin
              if (stat.addrOk) begin
                cmd.ackOn   = 1'b1;
                cmd.ptrLoad = 1'b1;
                nxt         = ST_ACKADDR;
              end else begin
                nxt = ST_SKIP;
              end
            end else begin
              cmd.ackOn = 1'b1;
              cmd.wrStb = 1'b1;
              nxt       = ST_ACKDATA;
            end
          end
        end
        ST_ACKID: if (stat.sclFall) begin
          if (stat.rwBit) begin
            cmd.txLoad = 1'b1;
            nxt        = ST_TX;
          end else begin
            cmd.relSda = 1'b1;
            cmd.clrCnt = 1'b1;
            nxt        = ST_RXADDR;
          end
        end
        ST_ACKADDR: if (stat.sclFall) begin
          cmd.relSda = 1'b1;
          cmd.clrCnt = 1'b1;
          nxt        = ST_RXDATA;
        end
        ST_ACKDATA: if (stat.sclFall) begin
          cmd.relSda = 1'b1;
          nxt        = ST_SKIP;
        end
        ST_TX: if (stat.sclFall) begin
          if (stat.byteDone) begin
            cmd.relSda = 1'b1;
            cmd.ptrInc = 1'b1;
            nxt        = ST_TXACK;
          end else begin
            cmd.txShift = 1'b1;
          end
        end
        ST_TXACK: if (stat.sclRise) begin
          nxt = stat.sdaNow ? ST_SKIP : ST_TXWAIT;
        end
        ST_TXWAIT: if (stat.sclFall) begin
          cmd.txLoad = 1'b1;
          nxt        = ST_TX;
        end
        default: ;
      endcase
    end
  end

  assign curState = state;
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_REGS    = 16,
  parameter logic [4:0] DEV_PREFIX  = 5'b10100,
  localparam int        ADDR_W      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [1:0]        devSel,
  input  logic              busyIn,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  input  logic [BYTE_W-1:0] regRdData
);
  dpCmd_t     cmd;
  dpStat_t    stat;
  ctrlState_t curState;
  logic       sclSync;

  i2c_reg_dp #(
    .SYNC_STAGES(SYNC_STAGES), .NUM_REGS(NUM_REGS),
    .DEV_PREFIX(DEV_PREFIX), .ADDR_W(ADDR_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .devSel(devSel),
    .cmd(cmd), .stat(stat), .sclSync(sclSync), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData)
  );

  i2c_reg_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .busyIn(busyIn), .stat(stat),
    .cmd(cmd), .curState(curState)
  );
endmodule

// File: rtl/i2c_reg_chk.sv
module i2c_reg_chk
  import i2c_reg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdaOe,
  input logic              sclSync,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              busyIn,
  input logic              ptrInc,
  input ctrlState_t        curState
);
  // R10
  drive_in_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !$past(sclSync));

  // R5
  wr_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R5
  wr_acked_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> sdaOe);

  // R8
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE && busyIn) |=> curState == ST_IDLE);

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ptrInc |=> regAddr == ADDR_W'($past(regAddr) + 1'b1));

  // R7
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_SKIP) |-> !sdaOe);
endmodule

bind i2c_reg_slave i2c_reg_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .sclSync(sclSync),
  .regWrEn(regWrEn), .regAddr(regAddr), .busyIn(busyIn),
  .ptrInc(cmd.ptrInc), .curState(curState)
);

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic busyIn = 1'b0;
  logic [1:0] devSel = 2'b10;
  logic sdaOe, regWrEn;
  logic [3:0] regAddr;
  logic [7:0] regWrData, regRdData;
  wire  sdaBus = sdaM & ~sdaOe;

  logic [7:0] mem    [16];
  logic [7:0] refMem [16];
  int checks = 0, fails = 0, wrCount = 0, quietErr = 0, cycles = 0;
  logic [3:0] lastWA;
  logic [7:0] lastWD;
  logic quiet = 1'b0;

  always #2 clk = ~clk;

  i2c_reg_slave i_i2c_reg_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .devSel(devSel), .busyIn(busyIn), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  assign regRdData = mem[regAddr];

  always @(posedge clk) begin
    if (regWrEn) begin
      mem[regAddr] <= regWrData;
      wrCount <= wrCount + 1;
      lastWA  <= regAddr;
      lastWD  <= regWrData;
    end
  end

  // every clock: a silent slave must never pull SDA while SCL is high
  always @(negedge clk) if (quiet && sclM && sdaOe) quietErr++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitClk(input logic mBit, output logic busVal);
    waitN(4); sdaM = mBit; waitN(6);
    sclM = 1'b1; waitN(5); busVal = sdaBus; waitN(5);
    sclM = 1'b0;
  endtask

  task automatic startCond();
    waitN(4); sdaM = 1'b1; waitN(6); sclM = 1'b1; waitN(6);
    sdaM = 1'b0; waitN(6); sclM = 1'b0;
  endtask

  task automatic stopCond();
    waitN(4); sdaM = 1'b0; waitN(6); sclM = 1'b1; waitN(6);
    sdaM = 1'b1; waitN(10);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic d;
    for (int i = 7; i >= 0; i--) bitClk(b[i], d);
    bitClk(1'b1, d);
    acked = ~d;
  endtask

  task automatic recvByte(input logic mAck, output logic [7:0] b);
    logic d;
    for (int i = 7; i >= 0; i--) begin
      bitClk(1'b1, d);
      b[i] = d;
    end
    bitClk(~mAck, d);
  endtask

  function automatic logic [7:0] idByte(logic [4:0] pre, logic [1:0] sel, logic rw);
    return {pre, sel, rw};
  endfunction

  task automatic doWrite(input logic [7:0] a, input logic [7:0] d,
                         output logic k1, output logic k2, output logic k3);
    startCond();
    sendByte(idByte(5'b10100, devSel, 1'b0), k1);
    sendByte(a, k2);
    sendByte(d, k3);
    stopCond();
  endtask

  task automatic doRead(input logic [7:0] a, input int n);
    logic k;
    logic [7:0] b;
    startCond();
    sendByte(idByte(5'b10100, devSel, 1'b0), k); check("R2 read id ack", k, 1);
    sendByte(a, k);                              check("R4 read addr ack", k, 1);
    startCond();
    sendByte(idByte(5'b10100, devSel, 1'b1), k); check("R2 rd id ack", k, 1);
    for (int j = 0; j < n; j++) begin
      recvByte(j < n - 1, b);
      check("R6 read data", b, refMem[(a + j) % 16]);
    end
    stopCond();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i]    = 8'(i * 17) ^ 8'h3C;
      refMem[i] = 8'(i * 17) ^ 8'h3C;
    end
  end

  initial begin
    logic k1, k2, k3, d;
    int w0, zeros;
    waitN(5);
    check("R1 sdaOe reset", sdaOe, 0);
    check("R1 regWrEn reset", regWrEn, 0);
    check("R1 regAddr reset", regAddr, 0);
    rstN = 1'b1;
    waitN(10);

    // R2 R5 basic write
    w0 = wrCount;
    doWrite(8'h03, 8'hA5, k1, k2, k3);
    check("R2 id ack", k1, 1); check("R4 addr ack", k2, 1); check("R5 data ack", k3, 1);
    check("R5 write count", wrCount - w0, 1);
    check("R5 write addr", lastWA, 3); check("R5 write data", lastWD, 8'hA5);
    refMem[3] = 8'hA5;
    doWrite(8'h0F, 8'h5A, k1, k2, k3); refMem[15] = 8'h5A;
    check("R4 top addr ack", k2, 1);
    doWrite(8'h00, 8'hC3, k1, k2, k3); refMem[0] = 8'hC3;

    // R6 sequential read and wrap
    doRead(8'h03, 2);
    doRead(8'h0E, 4);

    // R7 master NACK ends the read
    startCond();
    sendByte(idByte(5'b10100, devSel, 1'b0), k1);
    sendByte(8'h05, k1);
    startCond();
    sendByte(idByte(5'b10100, devSel, 1'b1), k1);
    begin
      logic [7:0] b;
      recvByte(1'b0, b);
      check("R6 single read", b, refMem[5]);
    end
    quiet = 1'b1;
    zeros = 0;
    for (int i = 0; i < 9; i++) begin
      bitClk(1'b1, d);
      if (!d) zeros++;
    end
    check("R7 silent after nack", zeros, 0);
    stopCond();
    quiet = 1'b0;

    // R3 device byte mismatch: wrong select bits, then wrong prefix
    w0 = wrCount;
    quiet = 1'b1;
    startCond();
    sendByte(idByte(5'b10100, ~devSel, 1'b0), k1); check("R3 bad sel nack", k1, 0);
    sendByte(8'h02, k2);                           check("R3 addr ignored", k2, 0);
    sendByte(8'h77, k3);                           check("R3 data ignored", k3, 0);
    stopCond();
    startCond();
    sendByte(idByte(5'b10110, devSel, 1'b0), k1); check("R3 bad prefix nack", k1, 0);
    stopCond();
    quiet = 1'b0;
    check("R3 no write", wrCount - w0, 0);

    // R4 out-of-range address abandons the transaction
    w0 = wrCount;
    startCond();
    sendByte(idByte(5'b10100, devSel, 1'b0), k1);
    sendByte(8'h10, k2); check("R4 addr 10h nack", k2, 0);
    quiet = 1'b1;
    sendByte(8'h33, k3); check("R4 data after bad addr", k3, 0);
    stopCond();
    quiet = 1'b0;
    check("R4 no write", wrCount - w0, 0);

    // R5 extra data byte ignored
    w0 = wrCount;
    startCond();
    sendByte(idByte(5'b10100, devSel, 1'b0), k1);
    sendByte(8'h07, k2);
    sendByte(8'h11, k3); check("R5 first data ack", k3, 1);
    quiet = 1'b1;
    sendByte(8'h22, k3); check("R5 second data nack", k3, 0);
    stopCond();
    quiet = 1'b0;
    check("R5 one write only", wrCount - w0, 1);
    check("R5 kept first data", lastWD, 8'h11);
    refMem[7] = 8'h11;
    doRead(8'h07, 1);

    // R8 busy input masks START
    w0 = wrCount;
    busyIn = 1'b1; quiet = 1'b1;
    doWrite(8'h09, 8'h99, k1, k2, k3);
    check("R8 busy id nack", k1, 0); check("R8 busy data nack", k3, 0);
    busyIn = 1'b0; quiet = 1'b0;
    check("R8 busy no write", wrCount - w0, 0);

    // R9 bytes after STOP without START
    quiet = 1'b1;
    sendByte(idByte(5'b10100, devSel, 1'b0), k1);
    check("R9 standby nack", k1, 0);
    stopCond();
    quiet = 1'b0;

    // R2 other select value
    devSel = 2'b01;
    w0 = wrCount;
    doWrite(8'h01, 8'h3E, k1, k2, k3);
    check("R2 sel01 ack", k1, 1);
    check("R5 sel01 write", wrCount - w0, 1);
    refMem[1] = 8'h3E;
    doRead(8'h01, 1);

    check("R3 R7 quiet monitor", quietErr, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 200000) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=%0d expected=<200000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule